// File: doc/BRIEF.md
# Ethernet Transmit Frame Formatter

This block turns one frame held in transmit buffer memory into a byte stream for the transmit sequencer. A start strobe makes it read a 16-bit stored byte count and then the data bytes, one at a time, through a simple synchronous read port. Frames shorter than the minimum length can be filled out with zero bytes. A CRC-32 frame check sequence is computed over everything sent and appended to the frame. Software that supplies its own check sequence inside the data can turn this off.

Two control inputs are taken when the start strobe arrives: `pad_short` (fill short frames with zeros) and `fcs_skip` (append no CRC). The byte count is checked against the limit for the chosen CRC mode before any byte goes out. The sequencer takes bytes with a valid/ready handshake. It can stop a frame at any moment with `abort`, for example on loss of carrier. Every accepted start ends in exactly one single-cycle status pulse: done, aborted or error.

The controller is one state machine. Its states are IDLE, LEN_LO (low count byte arrives), LEN_HI (high count byte arrives), CHECK (count validated), FETCH (data read issued, or a pad byte chosen), LOAD (data byte captured), SEND (payload byte offered) and FCS (check-sequence byte offered).

Its transitions are as follows:
- IDLE goes to LEN_LO on start.
- LEN_LO goes to LEN_HI.
- LEN_HI goes to CHECK.
- CHECK goes to IDLE with an error when the count is invalid. Otherwise it goes to FETCH.
- FETCH goes to LOAD when the next payload byte is a data byte. It goes straight to SEND when the byte is a pad byte.
- LOAD goes to SEND.
- A SEND handshake goes to FETCH while payload bytes remain. After the last payload byte it goes to FCS, or to IDLE with done when CRC is off.
- The fourth FCS handshake goes to IDLE with done.
- `abort` in any state except IDLE goes to IDLE with aborted.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset `tx_valid`, `frame_done`, `frame_aborted` and `frame_error` are all low.
- R2: The stored count is read little-endian, with the low byte at address 0 and the high byte at address 1. Data byte i is read from address 2+i. Data bytes are sent in address order.
- R3: With `pad_short` high and a count below 64, bytes of value 0x00 follow the data until data plus pad total 64 bytes.
- R4: With `pad_short` low, the payload is exactly the stored number of data bytes, whatever the count.
- R5: With `fcs_skip` low, four CRC bytes follow the payload, least significant byte first. The CRC is CRC-32 with polynomial 0x04C11DB7, bits taken least significant first, initial value 0xFFFFFFFF and final inversion. It covers data and pad bytes.
- R6: With `fcs_skip` high, no CRC bytes are sent.
- R7: A count of 0 is rejected. So is a count above 1514 with `fcs_skip` low, or above 1518 with `fcs_skip` high. A rejected count gives one `frame_error` pulse and no bytes. A count of 1514 is accepted with CRC on, and a count of 1518 with CRC off.
- R8: `tx_last` is high only on the final byte of a frame. That is the last CRC byte, or the last payload byte when CRC is off. The cycle after that byte is taken, `frame_done` pulses once.
- R9: While `abort` is high after a start, `tx_valid` is low. The frame ends with no further bytes, including CRC bytes, and `frame_aborted` pulses once.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold until the next cycle unless `abort` is raised.
- R11: At most one of `frame_done`, `frame_aborted` and `frame_error` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin formatting the stored frame (taken in IDLE) |
| pad_short | input | 1 | Zero-pad short frames to 64 bytes |
| fcs_skip | input | 1 | Do not append the CRC |
| abort | input | 1 | Stop the current frame at once |
| mem_rd | output | 1 | Buffer read enable |
| mem_addr | output | 12 | Buffer read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| tx_valid | output | 1 | Byte offered to the sequencer |
| tx_ready | input | 1 | Sequencer takes the byte |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of the frame |
| frame_done | output | 1 | Frame completed (one-cycle pulse) |
| frame_aborted | output | 1 | Frame stopped by abort (one-cycle pulse) |
| frame_error | output | 1 | Byte count rejected (one-cycle pulse) |

## Verification
The hardest case to reach is an abort that lands inside the four CRC bytes. The handshake only reaches those bytes after the whole payload has been taken under back-pressure. The bench counts the bytes it has accepted and raises `abort` exactly when that count reaches the payload length plus two, so the abort falls between the second and third CRC byte. Other aborts are aimed at the length fetch and at the middle of the data. Random frames with random `tx_ready` stalls cover pad and CRC combinations, and directed counts sit on each side of both limits.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam logic [31:0] FCS_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] FCS_SEED      = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEN_LO,
        S_LEN_HI,
        S_CHECK,
        S_FETCH,
        S_LOAD,
        S_SEND,
        S_FCS
    } txf_state_e;

    // Advance a reflected CRC-32 register by one byte, low bit first.
    function automatic logic [31:0] fcs_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ FCS_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/txf_fcs.sv
module txf_fcs
    import txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);

    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= FCS_SEED;
        end else if (clr) begin
            crc_q <= FCS_SEED;
        end else if (en) begin
            crc_q <= fcs_step(crc_q, din);
        end
    end

    assign fcs = ~crc_q;

    // R5: every frame starts its CRC from the all-ones seed
    a_r5_seed_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fcs == 32'h0000_0000));

    // R5: CRC register only moves on an accepted payload byte or a clear
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(fcs));

endmodule

// File: rtl/txf_len.sv
module txf_len #(
    parameter int LEN_W   = 16,
    parameter int CNT_W   = 11,
    parameter int MIN_LEN = 64,
    parameter int MAX_HW  = 1514,
    parameter int MAX_SW  = 1518
) (
    input  logic [LEN_W-1:0] stored,
    input  logic             pad_on,
    input  logic             skip,
    output logic             bad,
    output logic [CNT_W-1:0] total
);

    localparam logic [LEN_W-1:0] LIM_HW = LEN_W'(MAX_HW);
    localparam logic [LEN_W-1:0] LIM_SW = LEN_W'(MAX_SW);
    localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);

    logic [LEN_W-1:0] limit;
    logic             short_frame;

    always_comb begin
        limit       = skip ? LIM_SW : LIM_HW;
        bad         = (stored == '0) || (stored > limit);
        short_frame = stored < MIN_L;
        if (pad_on && short_frame) begin
            total = CNT_W'(MIN_LEN);
        end else begin
            total = stored[CNT_W-1:0];
        end
    end

    // R3: an accepted frame never becomes shorter than its stored count
    always_comb begin
        if (!bad) begin
            a_r3_total_covers: assert (total >= stored[CNT_W-1:0]);
        end
    end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import txf_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_BASE = 2,
    parameter int MIN_LEN   = 64,
    parameter int MAX_HW    = 1514,
    parameter int MAX_SW    = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pad_short,
    input  logic              fcs_skip,
    input  logic              abort,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              frame_done,
    output logic              frame_aborted,
    output logic              frame_error
);

    localparam int LEN_W   = 16;
    localparam int CNT_W   = $clog2(MAX_SW + 1);
    localparam int FCS_N   = 4;
    localparam int FIDX_W  = $clog2(FCS_N);

    txf_state_e        state;
    logic              pad_q;
    logic              skip_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  pos_q;
    logic [7:0]        byte_q;
    logic [FIDX_W-1:0] fidx_q;
    logic              done_q;
    logic              abt_q;
    logic              err_q;

    logic              len_bad;
    logic [CNT_W-1:0]  len_total;
    logic [31:0]       fcs;
    logic              fcs_clr;
    logic              fcs_en;
    logic              in_data;
    logic              last_payload;
    logic              take;

    txf_len #(
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W),
        .MIN_LEN(MIN_LEN),
        .MAX_HW (MAX_HW),
        .MAX_SW (MAX_SW)
    ) u_len (
        .stored(cnt_q),
        .pad_on(pad_q),
        .skip  (skip_q),
        .bad   (len_bad),
        .total (len_total)
    );

    txf_fcs u_fcs (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fcs_clr),
        .en   (fcs_en),
        .din  (byte_q),
        .fcs  (fcs)
    );

    assign in_data      = {{(LEN_W-CNT_W){1'b0}}, pos_q} < cnt_q;
    assign last_payload = (pos_q == (total_q - CNT_W'(1)));
    assign take         = tx_valid && tx_ready;

    // State register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            pad_q   <= 1'b0;
            skip_q  <= 1'b0;
            cnt_q   <= '0;
            total_q <= '0;
            pos_q   <= '0;
            byte_q  <= '0;
            fidx_q  <= '0;
            done_q  <= 1'b0;
            abt_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            abt_q  <= 1'b0;
            err_q  <= 1'b0;
            if (state != S_IDLE && abort) begin
                state <= S_IDLE;
                abt_q <= 1'b1;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (start) begin
                            pad_q  <= pad_short;
                            skip_q <= fcs_skip;
                            pos_q  <= '0;
                            fidx_q <= '0;
                            state  <= S_LEN_LO;
                        end
                    end
                    S_LEN_LO: begin
                        cnt_q[7:0] <= mem_rdata;
                        state      <= S_LEN_HI;
                    end
                    S_LEN_HI: begin
                        cnt_q[15:8] <= mem_rdata;
                        state       <= S_CHECK;
                    end
                    S_CHECK: begin
                        if (len_bad) begin
                            err_q <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            total_q <= len_total;
                            state   <= S_FETCH;
                        end
                    end
                    S_FETCH: begin
                        if (in_data) begin
                            state <= S_LOAD;
                        end else begin
                            byte_q <= 8'h00;
                            state  <= S_SEND;
                        end
                    end
                    S_LOAD: begin
                        byte_q <= mem_rdata;
                        state  <= S_SEND;
                    end
                    S_SEND: begin
                        if (tx_ready) begin
                            pos_q <= pos_q + CNT_W'(1);
                            if (!last_payload) begin
                                state <= S_FETCH;
                            end else if (skip_q) begin
                                done_q <= 1'b1;
                                state  <= S_IDLE;
                            end else begin
                                state <= S_FCS;
                            end
                        end
                    end
                    S_FCS: begin
                        if (tx_ready) begin
                            fidx_q <= fidx_q + FIDX_W'(1);
                            if (fidx_q == FIDX_W'(FCS_N - 1)) begin
                                done_q <= 1'b1;
                                state  <= S_IDLE;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        tx_valid = 1'b0;
        tx_data  = byte_q;
        tx_last  = 1'b0;
        fcs_clr  = 1'b0;
        fcs_en   = 1'b0;
        unique case (state)
            S_IDLE: begin
                mem_rd  = start;
                fcs_clr = start;
            end
            S_LEN_LO: begin
                mem_rd   = 1'b1;
                mem_addr = ADDR_W'(1);
            end
            S_FETCH: begin
                mem_rd   = in_data;
                mem_addr = ADDR_W'(DATA_BASE) + ADDR_W'(pos_q);
            end
            S_SEND: begin
                tx_valid = !abort;
                tx_last  = tx_valid && skip_q && last_payload;
                fcs_en   = tx_valid && tx_ready;
            end
            S_FCS: begin
                tx_valid = !abort;
                tx_data  = fcs[{fidx_q, 3'b000} +: 8];
                tx_last  = tx_valid && (fidx_q == FIDX_W'(FCS_N - 1));
            end
            default: ;
        endcase
    end

    assign frame_done    = done_q;
    assign frame_aborted = abt_q;
    assign frame_error   = err_q;

    // R11: status pulses are mutually exclusive
    a_r11_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_done, frame_aborted, frame_error}));

    // R9: abort leaves the stream silent on the following cycle too
    a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && state != S_IDLE) |=> (!tx_valid && frame_aborted));

    // R7: a rejected count produces an error and no byte
    a_r7_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHECK && len_bad && !abort) |=> (frame_error && !tx_valid));

    // R8: once the final byte is taken the frame is finished
    a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tx_last) |=> (frame_done && !tx_valid));

    // R10: an offered byte holds while the sink stalls
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (abort || (tx_valid && $stable(tx_data))));

endmodule

// File: tb/eth_tx_framer_tb_top.sv
module eth_tx_framer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pad_short = 1'b0;
    logic        fcs_skip = 1'b0;
    logic        abort = 1'b0;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        frame_done;
    logic        frame_aborted;
    logic        frame_error;

    logic [7:0]  mem [0:4095];
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          stall_mode = 1'b1;

    always #5 clk = ~clk;

    eth_tx_framer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pad_short(pad_short),
        .fcs_skip(fcs_skip), .abort(abort), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .frame_done(frame_done),
        .frame_aborted(frame_aborted), .frame_error(frame_error)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bit-serial MSB-shift CRC over bits taken low bit first; reflect at the end.
    function automatic logic [31:0] ref_fcs(input logic [7:0] q[$]);
        logic [31:0] c;
        logic [31:0] r;
        logic        fb;
        c = 32'hFFFF_FFFF;
        foreach (q[k]) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ q[k][i];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        for (int i = 0; i < 32; i++) r[i] = c[31-i];
        return ~r;
    endfunction

    task automatic load_frame(input int cnt, input int ndata);
        mem[0] = cnt[7:0];
        mem[1] = cnt[15:8];
        for (int i = 0; i < ndata && i < 4094; i++) mem[2+i] = 8'($urandom);
    endtask

    // Run one frame; abort_at < 0 means no abort. kind: 0 done, 1 aborted, 2 error.
    task automatic run_frame(input int cnt, input bit pad, input bit skip,
                             input int abort_at, input string tag);
        logic [7:0] exp_q[$];
        logic [7:0] got_q[$];
        int         last_pos[$];
        int         exp_len, payload, kind, seen, hold_err, cyc;
        logic [31:0] f;
        bit         bad, stalled, abort_sent;
        logic [7:0] prev;
        bad = (cnt == 0) || (cnt > (skip ? 1518 : 1514));
        load_frame(cnt, bad ? 0 : cnt);
        payload = (pad && cnt < 64) ? 64 : cnt;
        if (!bad) begin
            for (int i = 0; i < payload; i++) exp_q.push_back(i < cnt ? mem[2+i] : 8'h00);
            if (!skip) begin
                f = ref_fcs(exp_q);
                for (int b = 0; b < 4; b++) exp_q.push_back(f[8*b +: 8]);
            end
        end
        exp_len = bad ? 0 : (abort_at >= 0 ? abort_at : exp_q.size());
        kind = bad ? 2 : (abort_at >= 0 ? 1 : 0);

        @(negedge clk);
        start = 1'b1; pad_short = pad; fcs_skip = skip;
        @(negedge clk);
        start = 1'b0;
        seen = -1; hold_err = 0; stalled = 1'b0; prev = 8'h00; abort_sent = 1'b0; cyc = 0;
        while (seen < 0 && cyc < 20000) begin
            tx_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;
            abort = (abort_at >= 0 && !abort_sent && got_q.size() == abort_at);
            #1;
            if (frame_done) seen = 0;
            else if (frame_aborted) seen = 1;
            else if (frame_error) seen = 2;
            if (abort) begin
                abort_sent = 1'b1;
                check(!tx_valid, {"R9 valid low during abort ", tag}, tx_valid, 0);
            end
            if (stalled && tx_valid && tx_data != prev) hold_err++;
            if (stalled && !tx_valid && !abort) hold_err++;
            if (tx_valid && tx_ready) begin
                got_q.push_back(tx_data);
                if (tx_last) last_pos.push_back(got_q.size() - 1);
            end
            stalled = tx_valid && !tx_ready;
            prev = tx_data;
            @(negedge clk);
            abort = 1'b0;
            cyc++;
        end
        tx_ready = 1'b0;
        if (seen < 0) begin
            if (frame_done) seen = 0;
            else if (frame_aborted) seen = 1;
            else if (frame_error) seen = 2;
        end
        check(seen == kind, {"R11/R7/R9 status kind ", tag}, seen, kind);
        check(got_q.size() == exp_len, {"R3/R4/R6/R7 byte count ", tag}, got_q.size(), exp_len);
        for (int i = 0; i < got_q.size() && i < exp_len; i++) begin
            if (got_q[i] != exp_q[i]) begin
                check(1'b0, {"R2/R5 byte value ", tag}, got_q[i], exp_q[i]);
                break;
            end
        end
        check(hold_err == 0, {"R10 hold under stall ", tag}, hold_err, 0);
        if (kind == 0) begin
            check(last_pos.size() == 1 && last_pos[0] == exp_len - 1,
                  {"R8 last on final byte ", tag},
                  last_pos.size() > 0 ? last_pos[0] : -1, exp_len - 1);
        end else begin
            check(last_pos.size() == 0, {"R8 no last on cut frame ", tag}, last_pos.size(), 0);
        end
        @(negedge clk);
        check(!frame_done && !frame_aborted && !frame_error,
              {"R11 single status pulse ", tag}, frame_done + frame_aborted + frame_error, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!tx_valid && !frame_done && !frame_aborted && !frame_error,
              "R1 outputs during reset", tx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid && !frame_done && !frame_aborted && !frame_error,
              "R1 outputs after reset", tx_valid, 0);

        stall_mode = 1'b0;
        run_frame(1,    1'b1, 1'b0, -1, "R3 pad 1 to 64");
        stall_mode = 1'b1;
        run_frame(63,   1'b1, 1'b0, -1, "R3 pad 63");
        run_frame(64,   1'b1, 1'b0, -1, "R3 no pad at 64");
        run_frame(10,   1'b0, 1'b0, -1, "R4 no pad short");
        run_frame(20,   1'b1, 1'b1, -1, "R6 pad without fcs");
        run_frame(300,  1'b0, 1'b1, -1, "R6 no fcs");
        run_frame(0,    1'b1, 1'b0, -1, "R7 zero count");
        run_frame(1514, 1'b0, 1'b0, -1, "R7 hw max ok");
        run_frame(1515, 1'b0, 1'b0, -1, "R7 hw max+1");
        run_frame(1515, 1'b0, 1'b1, -1, "R7 1515 ok sw");
        run_frame(1518, 1'b0, 1'b1, -1, "R7 sw max ok");
        run_frame(1519, 1'b0, 1'b1, -1, "R7 sw max+1");
        run_frame(40,   1'b0, 1'b0, 0,  "R9 abort before data");
        run_frame(40,   1'b0, 1'b0, 17, "R9 abort mid data");
        run_frame(40,   1'b1, 1'b0, 66, "R9 abort inside fcs");
        run_frame(5,    1'b1, 1'b0, 50, "R9 abort inside pad");

        for (int t = 0; t < 24; t++) begin
            int c;
            c = (t % 6 == 5) ? int'($urandom_range(1000, 1514)) : int'($urandom_range(1, 130));
            run_frame(c, 1'($urandom), 1'($urandom), -1, "R2/R5 random frame");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule